// File: doc/BRIEF.md
# Programmable Address Descriptor Decoder

This block routes each incoming memory or I/O request to a destination port by comparing its address against a small table of programmable descriptors. Each descriptor carries a valid bit, a kind, a 3-bit destination port and three 32-bit words. Depending on the kind, the descriptor claims an inclusive page span, a naturally aligned power-of-two region, or a window divided into pieces that are each claimed or passed on. Some kinds also relocate the outgoing address by a page-granular offset. A request that no descriptor claims goes to a fixed subtractive port with its address untouched.

Software loads the table one word at a time through a simple write port. Requests arrive with a valid strobe, a 32-bit address and a flag that selects I/O space. One cycle later the block returns the destination port, the translated address and a hit flag. Overlapping descriptors are a programming error. When two or more claim the same request, the lowest-numbered one wins and a sticky error flag is raised. Only a reset clears that flag. `rst_n` is asynchronous and active low, and it is expected to deassert synchronously to `clk`.

Top module: `addr_desc_decoder`

## Requirements
- R1: Table writes use `cfg_field` to pick a word of descriptor `cfg_idx`. Field 0 is control: bit 8 is valid, bits 6:4 are the kind, bits 2:0 are the port. Field 1 is LO, field 2 is HI and field 3 is AUX. Kind 0 (memory range) claims a memory request when its page number addr[31:12] lies between LO[31:12] and HI[31:12], both ends included. The address passes through unchanged.
- R2: Kind 1 (memory range with offset) matches as kind 0. The outgoing address is {addr[31:12] + AUX[31:12] modulo 2^20, addr[11:0]}, so the low 12 bits are never changed.
- R3: Kind 2 (memory base-mask) claims a memory request when addr[31:12] and LO[31:12] agree on every bit set in HI[31:12]. The address passes through unchanged.
- R4: Kind 3 (memory base-mask with offset) matches as kind 2 and translates the address as in R2, with wrap-around past the top of the 32-bit space.
- R5: Kind 4 (memory piecewise) covers the 256 KB window with addr[31:18] == LO[31:18]. Piece p = addr[17:14] is claimed only when AUX[p] is 1. An unclaimed piece goes to the subtractive port.
- R6: Kind 5 (I/O base-mask) claims an I/O request when addr and LO agree on every bit set in HI, at byte granularity. I/O kinds never claim memory requests, and memory kinds never claim I/O requests.
- R7: Kind 6 (I/O piecewise) covers the 8-byte window with addr[31:3] == LO[31:3]. Byte p = addr[2:0] is claimed only when AUX[p] is 1.
- R8: An unclaimed request returns `rsp_hit`=0, `rsp_port`=SUB_PORT (default 7) and `rsp_addr` equal to the request address.
- R9: When more than one descriptor claims a request, the lowest-numbered one supplies port and address. `overlap_err` then goes to 1 and stays at 1 until reset.
- R10: A descriptor whose valid bit is 0, or whose kind is 7, never claims a request.
- R11: Each request cycle gives exactly one response on the following cycle, with `rsp_valid` high. A cycle without a request gives `rsp_valid` low on the following cycle.
- R12: After reset, `rsp_valid` and `overlap_err` are 0 and every descriptor is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Descriptor number to write |
| cfg_field | input | 2 | Word select: 0 control, 1 LO, 2 HI, 3 AUX |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_io | input | 1 | 1 selects I/O space, 0 selects memory space |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | A descriptor claimed the request |
| rsp_port | output | 3 | Destination port |
| rsp_addr | output | 32 | Translated address |
| overlap_err | output | 1 | Sticky multiple-claim flag |

## Verification
Every result (`rsp_valid`, `rsp_hit`, `rsp_port`, `rsp_addr`) is registered once. A request is therefore due exactly one clock after it is presented, and a table write applies to requests presented from the cycle after the write. `overlap_err` rises in the same cycle as the response to the first doubly claimed request. The bench drives each request on a falling edge and compares all four results on the next falling edge, after exactly one rising edge. It checks against a model held in bench functions and loaded through the same table writes. It samples `overlap_err` at that same point and again after later requests and idle cycles, to show that the flag holds.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int DA_W      = 32;  // address width
  localparam int DP_W      = 3;   // destination port width
  localparam int PAGE_B    = 12;  // 4 KB page granularity
  localparam int MWIN_B    = 18;  // 256 KB memory piecewise window
  localparam int MPIECE_B  = 14;  // 16 KB memory pieces
  localparam int IOWIN_B   = 3;   // 8-byte I/O piecewise window
  localparam int PG_W      = DA_W - PAGE_B;

  typedef enum logic [2:0] {
    K_RANGE     = 3'd0,
    K_RANGE_OFS = 3'd1,
    K_BM        = 3'd2,
    K_BM_OFS    = 3'd3,
    K_MPIECE    = 3'd4,
    K_IO_BM     = 3'd5,
    K_IO_PIECE  = 3'd6,
    K_NONE      = 3'd7
  } desc_kind_e;

  typedef struct packed {
    logic            valid;
    desc_kind_e      kind;
    logic [DP_W-1:0] port;
    logic [DA_W-1:0] lo;
    logic [DA_W-1:0] hi;
    logic [DA_W-1:0] aux;
  } desc_t;
endpackage

// File: rtl/desc_regfile.sv
module desc_regfile
  import addr_dec_pkg::*;
#(
  parameter int N_DESC = 4,
  localparam int IDX_W = (N_DESC > 1) ? $clog2(N_DESC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [1:0]             cfg_field,
  input  logic [DA_W-1:0]        cfg_wdata,
  output desc_t [N_DESC-1:0]     descs
);
  for (genvar gi = 0; gi < N_DESC; gi++) begin : g_desc
    desc_t d_q, d_d;
    logic  wr_en;

    assign wr_en = cfg_we && (cfg_idx == IDX_W'(gi));

    always_comb begin
      d_d = d_q;
      unique case (cfg_field)
        2'd0: begin
          d_d.valid = cfg_wdata[8];
          d_d.kind  = desc_kind_e'(cfg_wdata[6:4]);
          d_d.port  = cfg_wdata[DP_W-1:0];
        end
        2'd1: d_d.lo  = cfg_wdata;
        2'd2: d_d.hi  = cfg_wdata;
        default: d_d.aux = cfg_wdata;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '{valid: 1'b0, kind: K_NONE, port: '0, lo: '0, hi: '0, aux: '0};
      end else if (wr_en) begin
        d_q <= d_d;
      end
    end

    assign descs[gi] = d_q;
  end
endmodule

// File: rtl/desc_match.sv
module desc_match
  import addr_dec_pkg::*;
(
  input  desc_t           d,
  input  logic [DA_W-1:0] addr,
  input  logic            io,
  output logic            hit,
  output logic [DA_W-1:0] xaddr
);
  logic [PG_W-1:0] pg, lo_pg, hi_pg, ofs_pg;
  logic            in_range, in_bm, m_win, m_claim, io_bm, io_win, io_claim;
  logic [MWIN_B-MPIECE_B-1:0] m_sel;
  logic [IOWIN_B-1:0]         io_sel;

  always_comb begin
    pg     = addr[DA_W-1:PAGE_B];
    lo_pg  = d.lo[DA_W-1:PAGE_B];
    hi_pg  = d.hi[DA_W-1:PAGE_B];
    ofs_pg = d.aux[DA_W-1:PAGE_B];

    in_range = (pg >= lo_pg) && (pg <= hi_pg);
    in_bm    = ((pg ^ lo_pg) & hi_pg) == '0;

    m_sel    = addr[MWIN_B-1:MPIECE_B];
    m_win    = addr[DA_W-1:MWIN_B] == d.lo[DA_W-1:MWIN_B];
    m_claim  = d.aux[m_sel];

    io_bm    = ((addr ^ d.lo) & d.hi) == '0;
    io_sel   = addr[IOWIN_B-1:0];
    io_win   = addr[DA_W-1:IOWIN_B] == d.lo[DA_W-1:IOWIN_B];
    io_claim = d.aux[io_sel];

    hit   = 1'b0;
    xaddr = addr;
    unique case (d.kind)
      K_RANGE:     hit = !io && in_range;
      K_RANGE_OFS: hit = !io && in_range;
      K_BM:        hit = !io && in_bm;
      K_BM_OFS:    hit = !io && in_bm;
      K_MPIECE:    hit = !io && m_win && m_claim;
      K_IO_BM:     hit = io && io_bm;
      K_IO_PIECE:  hit = io && io_win && io_claim;
      default:     hit = 1'b0;
    endcase
    hit = hit && d.valid;

    if (d.kind == K_RANGE_OFS || d.kind == K_BM_OFS) begin
      xaddr = {pg + ofs_pg, addr[PAGE_B-1:0]};
    end
  end
endmodule

// File: rtl/prio_select.sv
module prio_select
  import addr_dec_pkg::*;
#(
  parameter int N_DESC = 4
) (
  input  logic [N_DESC-1:0]           hits,
  input  logic [N_DESC-1:0][DA_W-1:0] xaddrs,
  input  logic [N_DESC-1:0][DP_W-1:0] ports,
  output logic                        any_hit,
  output logic                        multi_hit,
  output logic [DA_W-1:0]             sel_addr,
  output logic [DP_W-1:0]             sel_port
);
  always_comb begin
    sel_addr = '0;
    sel_port = '0;
    for (int i = N_DESC - 1; i >= 0; i--) begin
      if (hits[i]) begin
        sel_addr = xaddrs[i];
        sel_port = ports[i];
      end
    end
    any_hit   = |hits;
    multi_hit = (hits & (hits - N_DESC'(1))) != '0;
  end
endmodule

// File: rtl/addr_desc_decoder.sv
module addr_desc_decoder
  import addr_dec_pkg::*;
#(
  parameter int          N_DESC   = 4,
  parameter logic [2:0]  SUB_PORT = 3'd7,
  localparam int         IDX_W    = (N_DESC > 1) ? $clog2(N_DESC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [1:0]       cfg_field,
  input  logic [31:0]      cfg_wdata,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic             req_io,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [2:0]       rsp_port,
  output logic [31:0]      rsp_addr,
  output logic             overlap_err
);
  desc_t [N_DESC-1:0]           descs;
  logic  [N_DESC-1:0]           hits;
  logic  [N_DESC-1:0][DA_W-1:0] xaddrs;
  logic  [N_DESC-1:0][DP_W-1:0] ports;
  logic                         any_hit, multi_hit;
  logic  [DA_W-1:0]             sel_addr;
  logic  [DP_W-1:0]             sel_port;

  desc_regfile #(.N_DESC(N_DESC)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .descs(descs)
  );

  for (genvar gi = 0; gi < N_DESC; gi++) begin : g_match
    desc_match u_match (
      .d(descs[gi]), .addr(req_addr), .io(req_io),
      .hit(hits[gi]), .xaddr(xaddrs[gi])
    );
    assign ports[gi] = descs[gi].port;
  end

  prio_select #(.N_DESC(N_DESC)) u_sel (
    .hits(hits), .xaddrs(xaddrs), .ports(ports),
    .any_hit(any_hit), .multi_hit(multi_hit),
    .sel_addr(sel_addr), .sel_port(sel_port)
  );

  // next-state
  logic            hit_d, err_d;
  logic [DP_W-1:0] port_d;
  logic [DA_W-1:0] addr_d;

  always_comb begin
    hit_d  = any_hit;
    port_d = any_hit ? sel_port : SUB_PORT;
    addr_d = any_hit ? sel_addr : req_addr;
    err_d  = overlap_err || (req_valid && multi_hit);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      overlap_err <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      overlap_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit  <= 1'b0;
      rsp_port <= '0;
      rsp_addr <= '0;
    end else if (req_valid) begin
      rsp_hit  <= hit_d;
      rsp_port <= port_d;
      rsp_addr <= addr_d;
    end
  end
endmodule

// File: rtl/addr_desc_decoder_chk.sv
module addr_desc_decoder_chk #(
  parameter logic [2:0] SUB_PORT = 3'd7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [2:0]  rsp_port,
  input logic [31:0] rsp_addr,
  input logic        overlap_err
);
  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R8
  miss_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_port == SUB_PORT));
  // R8
  miss_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit || rsp_addr == $past(req_addr)));
  // R2
  page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_addr[11:0] == $past(req_addr[11:0])));
  // R9
  sticky_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |=> overlap_err);
endmodule

bind addr_desc_decoder addr_desc_decoder_chk #(.SUB_PORT(SUB_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_port(rsp_port),
  .rsp_addr(rsp_addr), .overlap_err(overlap_err)
);

// File: tb/tb_addr_desc_decoder.sv
module tb_addr_desc_decoder;
  localparam int N = 4;
  localparam logic [2:0] SUBP = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [1:0]  cfg_field;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_io;
  logic        rsp_valid, rsp_hit, overlap_err;
  logic [2:0]  rsp_port;
  logic [31:0] rsp_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  addr_desc_decoder #(.N_DESC(N), .SUB_PORT(SUBP)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_io(req_io), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_port(rsp_port), .rsp_addr(rsp_addr),
    .overlap_err(overlap_err)
  );

  // bench copy of the table, loaded by the same writes
  logic        m_valid [N];
  logic [2:0]  m_kind  [N];
  logic [2:0]  m_port  [N];
  logic [31:0] m_lo    [N];
  logic [31:0] m_hi    [N];
  logic [31:0] m_aux   [N];
  logic        m_err;

  function automatic string kind_tag(input int k);
    case (k)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic void model(input logic [31:0] a, input logic io,
                                output logic h, output logic [2:0] p,
                                output logic [31:0] xa, output int nm,
                                output int fk);
    h = 0; p = SUBP; xa = a; nm = 0; fk = 8;
    for (int i = 0; i < N; i++) begin
      logic c;
      logic [19:0] pg, lp, hp;
      pg = a[31:12]; lp = m_lo[i][31:12]; hp = m_hi[i][31:12];
      c = 0;
      case (m_kind[i])
        3'd0, 3'd1: c = !io && pg >= lp && pg <= hp;
        3'd2, 3'd3: c = !io && ((pg & hp) == (lp & hp));
        3'd4: c = !io && a[31:18] == m_lo[i][31:18] && m_aux[i][a[17:14]];
        3'd5: c = io && ((a & m_hi[i]) == (m_lo[i] & m_hi[i]));
        3'd6: c = io && a[31:3] == m_lo[i][31:3] && m_aux[i][a[2:0]];
        default: c = 0;
      endcase
      c = c && m_valid[i];
      if (c) begin
        nm++;
        if (!h) begin
          h = 1; p = m_port[i]; fk = int'(m_kind[i]);
          if (m_kind[i] == 3'd1 || m_kind[i] == 3'd3)
            xa = {a[31:12] + m_aux[i][31:12], a[11:0]};
        end
      end
    end
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int fld, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_field = 2'(fld); cfg_wdata = v;
    case (fld)
      0: begin m_valid[idx] = v[8]; m_kind[idx] = v[6:4]; m_port[idx] = v[2:0]; end
      1: m_lo[idx] = v;
      2: m_hi[idx] = v;
      default: m_aux[idx] = v;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic setd(input int idx, input bit v, input int k, input int p,
                      input logic [31:0] lo, input logic [31:0] hi,
                      input logic [31:0] aux);
    wr(idx, 1, lo); wr(idx, 2, hi); wr(idx, 3, aux);
    wr(idx, 0, {23'd0, v, 1'b0, 3'(k), 1'b0, 3'(p)});
  endtask

  // one request, checked one clock later; tag "" picks the tag from the model
  task automatic req(input logic [31:0] a, input logic io, input string tag);
    logic h; logic [2:0] p; logic [31:0] xa; int nm, fk;
    string t;
    model(a, io, h, p, xa, nm, fk);
    t = (tag == "") ? kind_tag(fk) : tag;
    if (nm > 1) m_err = 1;
    req_valid = 1; req_addr = a; req_io = io;
    @(negedge clk);
    req_valid = 0;
    check("R11", rsp_valid === 1'b1, "rsp_valid", 32'(rsp_valid), 32'd1);
    check(t, rsp_hit === h, "rsp_hit", 32'(rsp_hit), 32'(h));
    check(t, rsp_port === p, "rsp_port", 32'(rsp_port), 32'(p));
    check(t, rsp_addr === xa, "rsp_addr", rsp_addr, xa);
    check("R9", overlap_err === m_err, "overlap_err", 32'(overlap_err), 32'(m_err));
  endtask

  function automatic logic [31:0] pick_addr(output logic io);
    int i = int'($urandom % N);
    int r = int'($urandom % 4);
    logic [31:0] a;
    io = m_kind[i] == 3'd5 || m_kind[i] == 3'd6;
    if ($urandom % 8 == 0) io = ~io;
    case (r)
      0: a = $urandom;
      1: a = m_lo[i] + ($urandom % 32'h2000) - 32'h1000;
      2: a = m_hi[i] + ($urandom % 32'h2000) - 32'h1000;
      default: a = m_lo[i] + ($urandom % 32'h40000);
    endcase
    if (io && r != 0) a = m_lo[i] + ($urandom % 16) - 4;
    return a;
  endfunction

  task automatic random_burst(input int n);
    for (int k = 0; k < n; k++) begin
      logic io; logic [31:0] a;
      a = pick_addr(io);
      req(a, io, "");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_field = 0; cfg_wdata = 0;
    req_valid = 0; req_addr = 0; req_io = 0; m_err = 0;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_kind[i] = 3'd7; m_port[i] = 0;
      m_lo[i] = 0; m_hi[i] = 0; m_aux[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12", rsp_valid === 1'b0, "rsp_valid", 32'(rsp_valid), 0);
    check("R12", overlap_err === 1'b0, "overlap_err", 32'(overlap_err), 0);
    req(32'h0010_0000, 0, "R12");  // empty table: miss

    // stage A
    setd(0, 1, 0, 1, 32'h0010_0000, 32'h0E7B_FFFF, 0);
    setd(1, 1, 1, 2, 32'h4040_0000, 32'h4043_FFFF, 32'h1000_0000);
    setd(2, 1, 4, 3, 32'h000C_0000, 0, 32'h0000_00F0);
    setd(3, 1, 5, 4, 32'h0000_6000, 32'hFFFF_FF00, 0);
    req(32'h0010_0000, 0, "R1");  // lower bound
    req(32'h0E7B_FFFF, 0, "R1");  // upper bound
    req(32'h0E7C_0000, 0, "R8");  // just past
    req(32'h000F_FFFF, 0, "R8");  // just below
    req(32'h4040_1234, 0, "R2");  // -> 5040_1234
    req(32'h000D_0000, 0, "R5");  // piece 4 claimed
    req(32'h000C_0000, 0, "R5");  // piece 0 unclaimed
    req(32'h000D_FFFF, 0, "R5");  // piece 7 claimed
    req(32'h000E_0000, 0, "R5");  // piece 8 unclaimed
    req(32'h0000_60AB, 1, "R6");
    req(32'h0000_6100, 1, "R6");
    req(32'h0000_6000, 0, "R6");  // memory request, I/O kind
    req(32'h0010_0000, 1, "R6");  // I/O request, memory kind
    @(negedge clk);               // idle cycle
    check("R11", rsp_valid === 1'b0, "rsp_valid idle", 32'(rsp_valid), 0);
    random_burst(400);

    // stage B
    setd(0, 1, 2, 5, 32'h5000_0000, 32'hFF80_0000, 0);
    setd(1, 1, 3, 6, 32'hFFFC_0000, 32'hFFFC_0000, 32'h0010_0000);
    setd(2, 1, 6, 1, 32'h0000_0020, 0, 32'h0000_0003);
    setd(3, 0, 0, 2, 32'h0000_0000, 32'hFFFF_FFFF, 0);
    req(32'h507F_FFFF, 0, "R3");
    req(32'h5080_0000, 0, "R3");
    req(32'hFFFF_F123, 0, "R4");  // wraps to 000F_F123
    req(32'h0000_0021, 1, "R7");
    req(32'h0000_0022, 1, "R7");
    req(32'h0000_0028, 1, "R7");
    req(32'h1234_5000, 0, "R10"); // invalid descriptor covers everything
    setd(3, 1, 7, 2, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    req(32'h1234_5000, 0, "R10"); // kind 7 never claims
    random_burst(400);

    // stage C: overlap
    setd(0, 1, 0, 2, 32'h1000_0000, 32'h1FFF_FFFF, 0);
    setd(1, 1, 0, 3, 32'h1800_0000, 32'h1800_FFFF, 0);
    req(32'h1900_0000, 0, "R9");  // single claim, no error yet
    req(32'h1800_1000, 0, "R9");  // both claim: port 2, error set
    req(32'h2000_0000, 0, "R9");  // miss, error holds
    @(negedge clk);
    check("R9", overlap_err === 1'b1, "overlap_err held", 32'(overlap_err), 1);
    random_burst(200);

    // reset again
    rst_n = 0;
    @(negedge clk);
    rst_n = 1; m_err = 0;
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    @(negedge clk);
    check("R12", overlap_err === 1'b0, "overlap_err", 32'(overlap_err), 0);
    check("R12", rsp_valid === 1'b0, "rsp_valid", 32'(rsp_valid), 0);
    req(32'h1800_1000, 0, "R12"); // table cleared: miss

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule